// File: doc/BRIEF.md
# Memory-Side SEC-DED Latch and Mode Datapath

This block sits between a processor bus and a memory array that stores each data word with a 7-bit check word. A 2-bit mode select steers it through five kinds of operation:

- generating a check word on the way to memory;
- flagging errors on the way back;
- freezing a word that was read;
- correcting that word;
- a diagnostic mode that tests data words against a fixed, captured check word.

A separate output latch, loaded on the rising edge of a strobe, holds the corrected word. Per-byte disables let the host replace single bytes of that word. The merged word then gets a fresh check word for write-back.

The bidirectional data and check buses appear as separate input, output and output-enable signals. All latches are registers clocked by a free-running clock. A "transparent" latch follows its input with no delay. A held latch keeps the value its input had in the last cycle before the hold began.

Top module: `edac_latch_path`

## Requirements
- R1: With sel=2'b00 (write), both flags are low. The check port shows the code of the merged word. For check bit j<6, it is the XOR of the data bits i whose column c(i) has bit j set. Column c(i) is the i-th integer, counting from 3 upward, that is not a power of two. Bit 6 makes the parity of all 39 bits even.
- R2: With sel=2'b10 (read), both input latches follow data_in and chk_in. The check port echoes chk_in, and the flags classify the incoming word.
- R3: On entry to sel=2'b11 (correct), the values present in the last cycle before the switch are held. While that mode lasts, changes on data_in and chk_in have no effect on the flags, the syndrome or the corrected word.
- R4: In correct mode the check port shows the syndrome. Bit 6 is the overall parity of the held 39 bits, and bits 5:0 are the recomputed low code XOR the held low check bits. When bit 6 is set, the data bit whose column equals bits 5:0 is inverted in the corrected word.
- R5: A word with no error gives err_flag=0 and multi_flag=0. Any single flipped bit, in data or check, gives err_flag=1 and multi_flag=0. Any two flipped bits give both flags high.
- R6: The output latch loads the corrected word only in a cycle where out_strobe is high and was low in the previous cycle. At all other times it holds.
- R7: data_out always carries the output latch. data_oe[b] is the inverse of byte_dis[b], where byte b covers bits 8b+7:8b.
- R8: In write mode the word that is encoded takes byte b from data_in when byte_dis[b]=1 and from the output latch when byte_dis[b]=0.
- R9: With sel=2'b01 (diagnostic), the check latch holds the value from the last cycle before entry while the data latch follows data_in. The flags classify data_in against that fixed check word.
- R10: In read and diagnostic modes the check port shows the check latch contents, so a captured check word can be read back in diagnostic mode.
- R11: Switching from diagnostic to correct mode holds the last diagnostic data word. The syndrome is {1, c(i)} for an injected flip in data bit i, and the corrected word equals the original data.
- R12: After reset the output latch and both input latches are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Mode: 00 write, 01 diagnostic, 10 read, 11 correct |
| out_strobe | input | 1 | Output latch load, acts on its rising edge |
| byte_dis | input | DATA_W/8 | Per-byte output disable and merge select |
| chk_dis | input | 1 | Check port output disable |
| data_in | input | DATA_W | Data bus input side |
| data_out | output | DATA_W | Output latch contents |
| data_oe | output | DATA_W/8 | Per-byte drive enable |
| chk_in | input | CHK_W | Check bus input side |
| chk_out | output | CHK_W | Generated code, syndrome or latched check word |
| chk_oe | output | 1 | Check port drive enable |
| err_flag | output | 1 | Any error detected |
| multi_flag | output | 1 | Uncorrectable error detected |

## Verification
The bench builds the block with the default DATA_W=32, which gives a 6-bit position field plus one overall parity bit. At this size the first and last data columns, a flip in every kind of check bit, and a data-plus-check double error can all be reached from a short vector table. Byte-merge write-back is driven with alternating external bytes, so that both merge sources appear in one encoded word. The diagnostic flow injects single and double flips against a captured check word and then corrects a flip in a middle bit.

// File: rtl/edac_pkg.sv
package edac_pkg;

  typedef enum logic [1:0] {
    SEL_WRITE   = 2'b00,
    SEL_DIAG    = 2'b01,
    SEL_READ    = 2'b10,
    SEL_CORRECT = 2'b11
  } sel_e;

  // smallest r with 2^r >= dw + r + 1
  function automatic int ham_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

endpackage

// File: rtl/edac_code.sv
module edac_code #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = 6
) (
  input  logic [DATA_W-1:0] gen_data,
  output logic [HAM_W:0]    gen_word,
  input  logic [DATA_W-1:0] chk_data,
  input  logic [HAM_W:0]    chk_word,
  output logic [HAM_W:0]    syndrome,
  output logic [DATA_W-1:0] fixed,
  output logic              err,
  output logic              multi
);

  // column of each data bit: successive non-powers of two from 3
  function automatic logic [DATA_W-1:0][HAM_W-1:0] build_cols();
    int v;
    v = 3;
    for (int i = 0; i < DATA_W; i++) begin
      while ((v & (v - 1)) == 0) v++;
      build_cols[i] = v[HAM_W-1:0];
      v++;
    end
  endfunction

  localparam logic [DATA_W-1:0][HAM_W-1:0] COLS = build_cols();

  function automatic logic [HAM_W:0] encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] lo;
    lo = '0;
    for (int j = 0; j < HAM_W; j++)
      for (int i = 0; i < DATA_W; i++)
        lo[j] = lo[j] ^ (d[i] & COLS[i][j]);
    return {(^d) ^ (^lo), lo};
  endfunction

  logic [HAM_W:0]    recode;
  logic [HAM_W-1:0]  syn_lo;
  logic [DATA_W-1:0] hit;
  logic              lone;
  logic              single_ok;

  assign gen_word = encode(gen_data);
  assign recode   = encode(chk_data);
  assign syndrome = {(^chk_data) ^ (^chk_word), recode[HAM_W-1:0] ^ chk_word[HAM_W-1:0]};
  assign syn_lo   = syndrome[HAM_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    assign hit[i] = syndrome[HAM_W] && (syn_lo == COLS[i]);
  end

  // zero or one bit set in the low field: a check bit was hit
  assign lone      = (syn_lo & (syn_lo - 1'b1)) == '0;
  assign single_ok = syndrome[HAM_W] && ((|hit) || lone);
  assign err       = |syndrome;
  assign multi     = err && !single_ok;
  assign fixed     = chk_data ^ hit;

endmodule

// File: rtl/edac_seq.sv
module edac_seq
  import edac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_e sel,
  input  logic strobe,
  output logic data_follow,
  output logic chk_follow,
  output logic out_load,
  output logic gen_mode,
  output logic syn_mode
);

  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign out_load    = strobe && !strobe_q;
  assign data_follow = (sel != SEL_CORRECT);
  assign chk_follow  = (sel == SEL_READ);
  assign gen_mode    = (sel == SEL_WRITE);
  assign syn_mode    = (sel == SEL_CORRECT);

endmodule

// File: rtl/edac_latch_path.sv
module edac_latch_path
  import edac_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int HAM_W  = ham_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              out_strobe,
  input  logic [NBYTES-1:0] byte_dis,
  input  logic              chk_dis,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic [NBYTES-1:0] data_oe,
  input  logic [CHK_W-1:0]  chk_in,
  output logic [CHK_W-1:0]  chk_out,
  output logic              chk_oe,
  output logic              err_flag,
  output logic              multi_flag
);

  sel_e sel_m;
  assign sel_m = sel_e'(sel);

  // named control events
  logic data_follow, chk_follow, out_load, gen_mode, syn_mode;

  edac_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel_m),
    .strobe     (out_strobe),
    .data_follow(data_follow),
    .chk_follow (chk_follow),
    .out_load   (out_load),
    .gen_mode   (gen_mode),
    .syn_mode   (syn_mode)
  );

  logic [DATA_W-1:0] din_hold, dout_lat, din_eff, merged, fixed;
  logic [CHK_W-1:0]  cin_hold, cin_eff, gen_word, syndrome;
  logic              core_err, core_multi;

  assign din_eff = data_follow ? data_in : din_hold;
  assign cin_eff = chk_follow  ? chk_in  : cin_hold;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = byte_dis[b] ? data_in[8*b +: 8] : dout_lat[8*b +: 8];
    assign data_oe[b]       = !byte_dis[b];
  end

  edac_code #(.DATA_W(DATA_W), .HAM_W(HAM_W)) i_code (
    .gen_data(merged),
    .gen_word(gen_word),
    .chk_data(din_eff),
    .chk_word(cin_eff),
    .syndrome(syndrome),
    .fixed   (fixed),
    .err     (core_err),
    .multi   (core_multi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_hold <= '0;
      cin_hold <= '0;
      dout_lat <= '0;
    end else begin
      if (data_follow) din_hold <= data_in;
      if (chk_follow)  cin_hold <= chk_in;
      if (out_load)    dout_lat <= fixed;
    end
  end

  always_comb begin
    if (gen_mode)      chk_out = gen_word;
    else if (syn_mode) chk_out = syndrome;
    else               chk_out = cin_eff;
  end

  assign data_out   = dout_lat;
  assign chk_oe     = !chk_dis;
  assign err_flag   = core_err && !gen_mode;
  assign multi_flag = core_multi && !gen_mode;

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_load |=> $stable(dout_lat));

  assert_correct_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_m == SEL_CORRECT) |=> ($stable(din_hold) && $stable(cin_hold)));

  assert_diag_chk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_m == SEL_DIAG) |=> $stable(cin_hold));

  assert_write_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_m == SEL_WRITE) |-> (!err_flag && !multi_flag));

  assert_multi_has_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    multi_flag |-> err_flag);

  assert_fix_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !multi_flag) |-> ($countones(fixed ^ din_eff) <= 1));

endmodule

// File: tb/test_edac_latch_path.sv
module test_edac_latch_path;

  localparam int DW = 32;
  localparam int CW = 7;
  localparam logic [1:0] M_WR = 2'b00, M_DG = 2'b01, M_RD = 2'b10, M_CR = 2'b11;
  localparam int NV = 10;
  // {data, data flip mask, check flip mask}
  localparam logic [70:0] VECS [NV] = '{
    {32'hA5A5_5A5A, 32'h0000_0000, 7'h00},
    {32'h1234_5678, 32'h0000_0001, 7'h00},
    {32'hDEAD_BEEF, 32'h8000_0000, 7'h00},
    {32'h0F0F_F0F0, 32'h0000_0000, 7'h40},
    {32'hCAFE_BABE, 32'h0000_0000, 7'h04},
    {32'h0000_0000, 32'h0001_0000, 7'h00},
    {32'hFFFF_FFFF, 32'h0000_0300, 7'h00},
    {32'h1357_9BDF, 32'h0000_0000, 7'h41},
    {32'h2468_ACE0, 32'h0010_0000, 7'h02},
    {32'h8765_4321, 32'h0000_8000, 7'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] sel = M_CR;
  logic out_strobe = 0, chk_dis = 0;
  logic [3:0] byte_dis = 4'hF;
  logic [DW-1:0] data_in = '0, data_out;
  logic [3:0] data_oe;
  logic [CW-1:0] chk_in = '0, chk_out;
  logic chk_oe, err_flag, multi_flag;

  int n_chk = 0, n_bad = 0;
  logic [5:0] bcol [DW];

  always #2.5 clk = ~clk;

  edac_latch_path i_edac_latch_path (
    .clk(clk), .rst_n(rst_n), .sel(sel), .out_strobe(out_strobe),
    .byte_dis(byte_dis), .chk_dis(chk_dis), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .chk_in(chk_in),
    .chk_out(chk_out), .chk_oe(chk_oe), .err_flag(err_flag),
    .multi_flag(multi_flag));

  // code as XOR of columns of the set data bits
  function automatic logic [CW-1:0] bgen(input logic [DW-1:0] d);
    logic [5:0] acc = '0;
    for (int i = 0; i < DW; i++) if (d[i]) acc ^= bcol[i];
    return {(^d) ^ (^acc), acc};
  endfunction

  function automatic logic [CW-1:0] bsyn(input logic [DW-1:0] d, input logic [CW-1:0] c);
    logic [CW-1:0] g = bgen(d);
    return {(^d) ^ (^c), g[5:0] ^ c[5:0]};
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic check_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic stb, input logic [3:0] bd,
                       input logic [DW-1:0] d, input logic [CW-1:0] c);
    @(negedge clk);
    sel = s; out_strobe = stb; byte_dis = bd; data_in = d; chk_in = c;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] d, dm, w, e, m;
    logic [CW-1:0] cm, c0;
    int nerr, idx;
    begin
      int v = 3;
      for (int i = 0; i < DW; i++) begin
        while ((v & (v - 1)) == 0) v++;
        bcol[i] = v[5:0];
        v++;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: reset state
    drive(M_CR, 0, 4'hF, 32'hFFFF_0000, 7'h55);
    check_eq("R12", "data_out after reset", data_out, 0);
    check_eq("R12", "syndrome of held zeros", chk_out, 0);
    check_eq("R12", "flags after reset", {err_flag, multi_flag}, 0);

    // R1: write generation
    drive(M_WR, 0, 4'hF, 32'h0000_0001, 7'h00);
    check_eq("R1", "code of bit0", chk_out, bgen(32'h1));
    check_eq("R1", "code of bit0 column", chk_out, {1'b1, 6'd3});
    drive(M_WR, 0, 4'hF, 32'hC3A5_0F96, 7'h7F);
    check_eq("R1", "code of pattern", chk_out, bgen(32'hC3A5_0F96));
    check_eq("R1", "flags in write", {err_flag, multi_flag}, 0);

    // vector table: read, then correct with disturbed inputs
    for (int k = 0; k < NV; k++) begin
      {d, dm, cm} = VECS[k];
      nerr = $countones(dm) + $countones(cm);
      drive(M_RD, 0, 4'hF, d ^ dm, bgen(d) ^ cm);
      check_eq("R5", $sformatf("flags v%0d", k), {err_flag, multi_flag}, {nerr > 0, nerr == 2});
      check_eq("R2", $sformatf("check echo v%0d", k), chk_out, bgen(d) ^ cm);
      drive(M_CR, 0, 4'hF, ~d, ~cm);
      check_eq("R4", $sformatf("syndrome v%0d", k), chk_out, bsyn(d ^ dm, bgen(d) ^ cm));
      check_eq("R3", $sformatf("held flags v%0d", k), {err_flag, multi_flag}, {nerr > 0, nerr == 2});
      if (nerr == 1 && dm != 0) begin
        idx = 0;
        for (int i = 0; i < DW; i++) if (dm[i]) idx = i;
        check_eq("R4", $sformatf("syndrome column v%0d", k), chk_out, {1'b1, bcol[idx]});
      end
      drive(M_CR, 1, 4'hF, 32'h0, 7'h0);
      drive(M_CR, 1, 4'hF, 32'h1, 7'h1);
      if (nerr <= 1) check_eq("R6", $sformatf("corrected word v%0d", k), data_out, d);
    end

    // R6: no reload while strobe stays high
    w = data_out;
    drive(M_RD, 1, 4'hF, 32'h1111_2222, bgen(32'h1111_2222));
    drive(M_RD, 1, 4'hF, 32'h1111_2222, bgen(32'h1111_2222));
    check_eq("R6", "level strobe holds", data_out, w);
    drive(M_RD, 0, 4'hF, 32'h1111_2222, bgen(32'h1111_2222));
    drive(M_RD, 1, 4'hF, 32'h1111_2222, bgen(32'h1111_2222));
    drive(M_RD, 0, 4'hF, 32'h0, 7'h0);
    check_eq("R6", "rising strobe loads", data_out, 32'h1111_2222);

    // R7 R8: byte merge write-back
    w = 32'h1111_2222;
    e = 32'hAABB_CCDD;
    m = {w[31:24], e[23:16], w[15:8], e[7:0]};
    drive(M_WR, 0, 4'b0101, e, 7'h0);
    check_eq("R7", "byte drive enables", data_oe, 4'b1010);
    check_eq("R7", "data_out is latch", data_out, w);
    check_eq("R8", "merged code", chk_out, bgen(m));
    drive(M_WR, 0, 4'b1010, e, 7'h0);
    check_eq("R8", "other merge", chk_out, bgen({e[31:24], w[23:16], e[15:8], w[7:0]}));

    // R9 R10 R11: diagnostic flow
    d = 32'h5A3C_96E1;
    c0 = bgen(d);
    drive(M_RD, 0, 4'hF, d, c0);
    drive(M_DG, 0, 4'hF, d ^ 32'h0000_0040, 7'h2A);
    check_eq("R9", "diag single flags", {err_flag, multi_flag}, 2'b10);
    check_eq("R10", "check readback", chk_out, c0);
    drive(M_DG, 0, 4'hF, d ^ 32'h0400_0002, 7'h15);
    check_eq("R9", "diag double flags", {err_flag, multi_flag}, 2'b11);
    drive(M_DG, 0, 4'hF, d, 7'h00);
    check_eq("R9", "diag clean flags", {err_flag, multi_flag}, 2'b00);
    drive(M_DG, 0, 4'hF, d ^ 32'h0010_0000, 7'h00);
    drive(M_CR, 0, 4'hF, 32'hFFFF_FFFF, 7'h7F);
    check_eq("R11", "diag syndrome", chk_out, {1'b1, bcol[20]});
    drive(M_CR, 1, 4'hF, 32'h0, 7'h0);
    drive(M_CR, 0, 4'hF, 32'h0, 7'h0);
    check_eq("R11", "diag corrected", data_out, d);

    report();
    $finish;
  end

endmodule